// File: doc/BRIEF.md
# Configuration Access Router

This block sits between a memory-mapped configuration window and a set of up to 256 function slots (32 devices with 8 functions each). Each incoming request is masked with a fixed address mask. The masked address then splits into a device number, a function number and an 8-bit register offset. The block checks the access size and the alignment. It then decides whether the request goes to a slot downstream or is answered locally.

A population vector marks which device/function slots exist. The block answers a read to an absent slot itself with all-ones at the access width. It answers a write to an absent slot, an unsupported size or a misaligned address with an error. None of these local cases reaches the downstream port. A legal access to a present slot goes out on a request port that carries the slot index, the offset, the size, the byte enables and lane-placed write data. That request stays up until the slot reports completion.

Only one request is in flight at a time. Every accepted request ends in a single-cycle response that carries right-justified read data and an error flag.

Top module: `cfg_route`

## Requirements
- R1: After reset `req_ready` is 1 and `dn_valid`, `rsp_valid` and `rsp_err` are 0.
- R2: The decode address is `req_addr & ADDR_MASK` (default mask 0x0000FFFF). `dn_slot` is decode address bits [15:8], with the device in [15:11] and the function in [10:8]. `dn_off` is bits [7:0]. Address bits the mask clears have no effect.
- R3: `req_size` is a byte count. Only 1, 2 and 4 are legal. Any other value gives a response with `rsp_err`=1 and `rsp_rdata`=0 in the cycle after acceptance, and no downstream request.
- R4: A 2-byte access with address bit 0 set, or a 4-byte access with address bits [1:0] nonzero, is handled as an error exactly as in R3.
- R5: `dn_be` has `req_size` consecutive ones starting at bit position address[1:0]. All other bits are zero.
- R6: A legal read to a slot whose `present` bit is 0 responds in the cycle after acceptance. The response has `rsp_err`=0 and `rsp_rdata` = 0xFF, 0xFFFF or 0xFFFFFFFF for sizes 1, 2 and 4. No downstream request is made.
- R7: A legal write to a slot whose `present` bit is 0 responds in the cycle after acceptance with `rsp_err`=1 and `rsp_rdata`=0. No downstream request is made.
- R8: A legal access to a present slot raises `dn_valid` in the cycle after acceptance. It holds `dn_valid` and all `dn_*` fields stable until `dn_rd_valid` (read) or `dn_wr_done` (write) is seen at a clock edge. For writes, `dn_wdata` is `req_wdata` cut to the access width and shifted left by 8×address[1:0]. The other bytes are zero.
- R9: A forwarded access responds in the cycle after completion with `rsp_err`=0. For a read, `rsp_rdata` = (`dn_rd_data` >> 8×address[1:0]) cut to the access width, with the upper bits zero. For a write, `rsp_rdata` is 0.
- R10: `req_ready` is 1 only while no request is held. `rsp_valid` is a one-cycle pulse, and `req_ready` is 1 again in the cycle after it.
- R11: `present` is sampled only in the acceptance cycle. Changing it while a request is held does not alter how that request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Configuration window address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Right-justified write data |
| present | input | 256 | Population vector indexed by {device, function} |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Right-justified read data |
| dn_valid | output | 1 | Downstream request held |
| dn_write | output | 1 | Downstream request is a write |
| dn_slot | output | 8 | Target {device, function} |
| dn_off | output | 8 | Register offset |
| dn_size | output | 3 | Access size in bytes |
| dn_be | output | 4 | Byte enables |
| dn_wdata | output | 32 | Lane-placed write data |
| dn_rd_valid | input | 1 | Slot returns read data |
| dn_rd_data | input | 32 | Lane-placed read data from slot |
| dn_wr_done | input | 1 | Slot completed write |

## Verification
The embedded properties watch, on every cycle, the shape of each downstream request. They check that the byte-enable count matches the size, that only legal sizes appear, that enables align to the offset, and that the fields hold until completion. They also check the one-cycle response pulse, that error responses never follow a downstream request, and that one-byte reads are zero-filled. Only the bench's sweep over every slot, size, lane and direction can show that the decoded slot and offset, the all-ones fill for absent slots, the data shifting in both directions and the acceptance-time sampling of the population vector give the right values.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

    localparam int CR_DEV_W  = 5;
    localparam int CR_FN_W   = 3;
    localparam int CR_OFF_W  = 8;
    localparam int CR_SLOT_W = CR_DEV_W + CR_FN_W;
    localparam int CR_SLOTS  = 1 << CR_SLOT_W;
    localparam int CR_DATA_W = 32;
    localparam int CR_BYTES  = CR_DATA_W / 8;
    localparam int CR_LANE_W = $clog2(CR_BYTES);
    localparam int CR_SIZE_W = CR_LANE_W + 1;

    typedef enum logic [1:0] {
        CR_IDLE = 2'd0,
        CR_FWD  = 2'd1,
        CR_RESP = 2'd2
    } cr_state_e;

    typedef struct packed {
        cr_state_e              state;
        logic                   write;
        logic [CR_SLOT_W-1:0]   slot;
        logic [CR_OFF_W-1:0]    off;
        logic [CR_SIZE_W-1:0]   size;
        logic [CR_LANE_W-1:0]   lane;
        logic [CR_BYTES-1:0]    be;
        logic [CR_DATA_W-1:0]   wdata;
        logic [CR_DATA_W-1:0]   rdata;
        logic                   err;
    } cr_regs_t;

endpackage

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
    import cfg_route_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(32'h0000_FFFF)
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CR_SIZE_W-1:0] size,
    output logic [CR_SLOT_W-1:0] slot,
    output logic [CR_OFF_W-1:0]  off,
    output logic [CR_LANE_W-1:0] lane,
    output logic                 size_ok,
    output logic [CR_BYTES-1:0]  be
);

    logic [ADDR_W-1:0]    daddr;
    logic                 pow2_ok;
    logic [CR_LANE_W-1:0] align_mask;

    assign daddr = addr & ADDR_MASK;
    assign slot  = daddr[CR_OFF_W +: CR_SLOT_W];
    assign off   = daddr[CR_OFF_W-1:0];
    assign lane  = daddr[CR_LANE_W-1:0];

    // legal sizes are the powers of two up to the bus width
    always_comb begin
        pow2_ok = 1'b0;
        for (int k = 0; k <= CR_LANE_W; k++) begin
            if (size == CR_SIZE_W'(1 << k)) pow2_ok = 1'b1;
        end
    end

    // low address bits must be zero within the access width
    assign align_mask = size[CR_LANE_W-1:0] - CR_LANE_W'(1);
    assign size_ok    = pow2_ok && ((lane & align_mask) == '0);

    for (genvar g = 0; g < CR_BYTES; g++) begin : g_be
        assign be[g] = size_ok && (g >= int'(lane)) && (g < int'(lane) + int'(size));
    end

endmodule

// File: rtl/cfg_route_lanes.sv
module cfg_route_lanes
    import cfg_route_pkg::*;
(
    input  logic [CR_SIZE_W-1:0] acc_size,
    input  logic [CR_LANE_W-1:0] acc_lane,
    input  logic [CR_DATA_W-1:0] acc_wdata,
    output logic [CR_DATA_W-1:0] acc_wlanes,
    output logic [CR_DATA_W-1:0] acc_ones,
    input  logic [CR_SIZE_W-1:0] hold_size,
    input  logic [CR_LANE_W-1:0] hold_lane,
    input  logic [CR_DATA_W-1:0] hold_lanes_in,
    output logic [CR_DATA_W-1:0] hold_rdata
);

    logic [CR_DATA_W-1:0] acc_narrow;
    logic [CR_DATA_W-1:0] hold_shifted;

    assign hold_shifted = hold_lanes_in >> {hold_lane, 3'b000};

    for (genvar g = 0; g < CR_BYTES; g++) begin : g_byte
        logic acc_keep;
        logic hold_keep;
        assign acc_keep  = g < int'(acc_size);
        assign hold_keep = g < int'(hold_size);
        assign acc_narrow[g*8 +: 8] = acc_keep  ? acc_wdata[g*8 +: 8]    : 8'h00;
        assign acc_ones[g*8 +: 8]   = acc_keep  ? 8'hFF                  : 8'h00;
        assign hold_rdata[g*8 +: 8] = hold_keep ? hold_shifted[g*8 +: 8] : 8'h00;
    end

    assign acc_wlanes = acc_narrow << {acc_lane, 3'b000};

endmodule

// File: rtl/cfg_route.sv
module cfg_route
    import cfg_route_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(32'h0000_FFFF)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CR_SIZE_W-1:0] req_size,
    input  logic [CR_DATA_W-1:0] req_wdata,
    input  logic [CR_SLOTS-1:0]  present,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [CR_DATA_W-1:0] rsp_rdata,
    output logic                 dn_valid,
    output logic                 dn_write,
    output logic [CR_SLOT_W-1:0] dn_slot,
    output logic [CR_OFF_W-1:0]  dn_off,
    output logic [CR_SIZE_W-1:0] dn_size,
    output logic [CR_BYTES-1:0]  dn_be,
    output logic [CR_DATA_W-1:0] dn_wdata,
    input  logic                 dn_rd_valid,
    input  logic [CR_DATA_W-1:0] dn_rd_data,
    input  logic                 dn_wr_done
);

    cr_regs_t q, d;

    logic [CR_SLOT_W-1:0] acc_slot;
    logic [CR_OFF_W-1:0]  acc_off;
    logic [CR_LANE_W-1:0] acc_lane;
    logic                 acc_ok;
    logic [CR_BYTES-1:0]  acc_be;
    logic [CR_DATA_W-1:0] acc_wlanes;
    logic [CR_DATA_W-1:0] acc_ones;
    logic [CR_DATA_W-1:0] hold_rdata;
    logic                 dn_done;

    cfg_route_decode #(
        .ADDR_W    (ADDR_W),
        .ADDR_MASK (ADDR_MASK)
    ) u_decode (
        .addr    (req_addr),
        .size    (req_size),
        .slot    (acc_slot),
        .off     (acc_off),
        .lane    (acc_lane),
        .size_ok (acc_ok),
        .be      (acc_be)
    );

    cfg_route_lanes u_lanes (
        .acc_size      (req_size),
        .acc_lane      (acc_lane),
        .acc_wdata     (req_wdata),
        .acc_wlanes    (acc_wlanes),
        .acc_ones      (acc_ones),
        .hold_size     (q.size),
        .hold_lane     (q.lane),
        .hold_lanes_in (dn_rd_data),
        .hold_rdata    (hold_rdata)
    );

    assign dn_done = q.write ? dn_wr_done : dn_rd_valid;

    always_comb begin
        d = q;
        unique case (q.state)
            CR_IDLE: begin
                if (req_valid) begin
                    d.write = req_write;
                    d.slot  = acc_slot;
                    d.off   = acc_off;
                    d.size  = req_size;
                    d.lane  = acc_lane;
                    d.be    = acc_be;
                    d.wdata = req_write ? acc_wlanes : '0;
                    d.rdata = '0;
                    d.err   = 1'b0;
                    if (!acc_ok) begin
                        d.state = CR_RESP;
                        d.err   = 1'b1;
                        d.be    = '0;
                        d.wdata = '0;
                    end else if (!present[acc_slot]) begin
                        d.state = CR_RESP;
                        d.err   = req_write;
                        d.rdata = req_write ? '0 : acc_ones;
                    end else begin
                        d.state = CR_FWD;
                    end
                end
            end
            CR_FWD: begin
                if (dn_done) begin
                    d.state = CR_RESP;
                    d.rdata = q.write ? '0 : hold_rdata;
                end
            end
            CR_RESP: begin
                d.state = CR_IDLE;
                d.err   = 1'b0;
            end
            default: d.state = CR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: CR_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.state == CR_IDLE);
    assign rsp_valid = (q.state == CR_RESP);
    assign rsp_err   = rsp_valid && q.err;
    assign rsp_rdata = rsp_valid ? q.rdata : '0;
    assign dn_valid  = (q.state == CR_FWD);
    assign dn_write  = q.write;
    assign dn_slot   = q.slot;
    assign dn_off    = q.off;
    assign dn_size   = q.size;
    assign dn_be     = q.be;
    assign dn_wdata  = q.wdata;

    AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> ($countones(dn_be) == int'(dn_size)));  // R5

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> (dn_size == 3'd1 || dn_size == 3'd2 || dn_size == 3'd4));  // R3

    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> ((dn_off[1:0] & (dn_size[1:0] - 2'd1)) == 2'd0));  // R4

    AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_done) |=> (dn_valid &&
            $stable({dn_write, dn_slot, dn_off, dn_size, dn_be, dn_wdata})));  // R8

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));  // R10

    AST_ERR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !$past(dn_valid));  // R7

    AST_NARROW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && q.size == 3'd1) |-> (rsp_rdata[CR_DATA_W-1:8] == '0));  // R9

endmodule

// File: tb/cfg_route_test.sv
`timescale 1ns/1ps
module cfg_route_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [2:0]   req_size = '0;
    logic [31:0]  req_wdata = '0;
    logic [255:0] present = '0;
    logic         rsp_valid, rsp_err;
    logic [31:0]  rsp_rdata;
    logic         dn_valid, dn_write;
    logic [7:0]   dn_slot, dn_off;
    logic [2:0]   dn_size;
    logic [3:0]   dn_be;
    logic [31:0]  dn_wdata;
    logic         dn_rd_valid = 1'b0;
    logic [31:0]  dn_rd_data = '0;
    logic         dn_wr_done = 1'b0;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [255:0] pat;

    always #2.5 clk = ~clk;

    cfg_route uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .present(present),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_slot(dn_slot), .dn_off(dn_off),
        .dn_size(dn_size), .dn_be(dn_be), .dn_wdata(dn_wdata),
        .dn_rd_valid(dn_rd_valid), .dn_rd_data(dn_rd_data), .dn_wr_done(dn_wr_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_fields(input bit wr, input logic [7:0] slot, input logic [7:0] off,
                                input logic [2:0] sz, input logic [3:0] be, input logic [31:0] wd);
        chk(dn_valid == 1'b1, "R8 dn_valid held", 32'(dn_valid), 32'd1);
        chk(dn_slot == slot, "R2 dn_slot", 32'(dn_slot), 32'(slot));
        chk(dn_off == off, "R2 dn_off", 32'(dn_off), 32'(off));
        chk(dn_size == sz, "R8 dn_size", 32'(dn_size), 32'(sz));
        chk(dn_be == be, "R5 dn_be", 32'(dn_be), 32'(be));
        chk(dn_write == wr, "R8 dn_write", 32'(dn_write), 32'(wr));
        if (wr) chk(dn_wdata == wd, "R8 dn_wdata", dn_wdata, wd);
    endtask

    task automatic txn(input bit wr, input logic [7:0] slot, input logic [7:0] off,
                       input logic [2:0] sz, input logic [31:0] wd);
        logic [1:0]  lane;
        logic [31:0] mask, exp_wd, rdv, exp_rd;
        logic [3:0]  exp_be;
        bit          ok, pres;
        int          lat;
        lane   = off[1:0];
        ok     = (sz == 3'd1) || (sz == 3'd2 && !lane[0]) || (sz == 3'd4 && lane == 2'd0);
        pres   = pat[slot];
        mask   = (sz == 3'd1) ? 32'h0000_00FF : (sz == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        exp_be = ok ? 4'((32'd1 << sz) - 32'd1) << lane : 4'h0;
        exp_wd = (wd & mask) << {lane, 3'b000};
        rdv    = {slot, off, ~slot, slot ^ off};
        exp_rd = (rdv >> {lane, 3'b000}) & mask;
        lat    = int'(slot) % 3;

        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {16'hC35A ^ {slot, ~slot}, slot, off};   // R2 upper bits masked off
        req_size  = sz;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 32'hFFFF_FFFF;
        present   = ~pat;                                     // R11 disturb after accept
        chk(req_ready == 1'b0, "R10 busy after accept", 32'(req_ready), 32'd0);
        if (!ok || !pres) begin
            chk(dn_valid == 1'b0, "R7 no downstream for local reply", 32'(dn_valid), 32'd0);
            chk(rsp_valid == 1'b1, "R6 local reply timing", 32'(rsp_valid), 32'd1);
            if (!ok) begin
                chk(rsp_err == 1'b1, "R3 R4 error flag", 32'(rsp_err), 32'd1);
                chk(rsp_rdata == 32'd0, "R3 error data", rsp_rdata, 32'd0);
            end else if (wr) begin
                chk(rsp_err == 1'b1, "R7 absent write error", 32'(rsp_err), 32'd1);
                chk(rsp_rdata == 32'd0, "R7 absent write data", rsp_rdata, 32'd0);
            end else begin
                chk(rsp_err == 1'b0, "R6 absent read no error", 32'(rsp_err), 32'd0);
                chk(rsp_rdata == mask, "R6 all-ones fill", rsp_rdata, mask);
            end
        end else begin
            check_fields(wr, slot, off, sz, exp_be, exp_wd);
            for (int c = 0; c < lat; c++) begin
                @(negedge clk);
                chk(rsp_valid == 1'b0, "R8 no reply before completion", 32'(rsp_valid), 32'd0);
                check_fields(wr, slot, off, sz, exp_be, exp_wd);
            end
            if (wr) dn_wr_done = 1'b1;
            else begin
                dn_rd_valid = 1'b1;
                dn_rd_data  = rdv;
            end
            @(negedge clk);
            dn_wr_done  = 1'b0;
            dn_rd_valid = 1'b0;
            dn_rd_data  = 32'hDEAD_BEEF;
            chk(dn_valid == 1'b0, "R8 request dropped after completion", 32'(dn_valid), 32'd0);
            chk(rsp_valid == 1'b1, "R9 reply after completion", 32'(rsp_valid), 32'd1);
            chk(rsp_err == 1'b0, "R11 R9 forwarded reply no error", 32'(rsp_err), 32'd0);
            chk(rsp_rdata == (wr ? 32'd0 : exp_rd), "R9 reply data", rsp_rdata, wr ? 32'd0 : exp_rd);
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 reply is one cycle", 32'(rsp_valid), 32'd0);
        chk(req_ready == 1'b1, "R10 ready after reply", 32'(req_ready), 32'd1);
        present = pat;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) pat[i] = ((i * 7 + 3) % 5) != 0;
        present = pat;
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        chk(dn_valid == 1'b0, "R1 reset dn_valid", 32'(dn_valid), 32'd0);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk(rsp_err == 1'b0, "R1 reset rsp_err", 32'(rsp_err), 32'd0);
        rst_n = 1'b1;
        for (int s = 0; s < 256; s++) begin
            for (int z = 0; z < 8; z++) begin
                for (int l = 0; l < 4; l++) begin
                    for (int w = 0; w < 2; w++) begin
                        txn(w[0], 8'(s), {6'(s * 5 + z), 2'(l)}, 3'(z),
                            32'h9E37_79B9 * 32'(s + 1) ^ 32'({z, l, w}));
                    end
                end
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R10 actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule